// File: doc/BRIEF.md
# Four-Phase Interleaved PWM Generator

This block drives the gates of four boost cells wired in parallel. It runs one carrier of `4*Q_CYC` clock cycles. The four outputs take that carrier with lags of zero, one, two and three quarter periods. The current controller supplies one duty word, and every phase uses it. The word waits in a shadow register. Each phase copies it into its own active register only when that phase starts a new period, so a pulse is never cut short or stretched in the middle. The phases start their periods at different times, so a new duty value reaches the power stage four times per carrier period. A one-cycle update tick marks each quarter boundary, and the sampling and control loop can run in step with it.

A pulse taken from the zero crossing of the AC input can realign the carrier. While the block runs, a sync pulse loads the master count with a programmed offset. The offset is given as a quarter index plus a fine count inside that quarter. Several converters can then sit at chosen angles against one line. The quarter spacing between the four outputs does not change when the carrier is realigned.

The sequencer has three states. IDLE holds the counters at zero and the outputs low. ARM lasts one cycle and copies the shadow duty into all four active registers. RUN advances the carrier. The transitions are *start* (IDLE to ARM when enable is high), *launch* (ARM to RUN when enable is still high) and *halt* (any state to IDLE when enable is low).

Top module: `ilv_pwm4`

## Requirements
- R1: While reset is asserted, and while the sequencer is not in RUN, all four `pwm` bits and `upd_tick` are 0. From the first cycle after enable falls until RUN is entered again, the outputs stay 0.
- R2: In RUN with a steady duty word, `pwm[0]` rises once every `4*Q_CYC` cycles. Each rise falls in the same cycle as an `upd_tick` pulse.
- R3: `pwm[k]` (bit k, k = 0..3) lags `pwm[0]` by `k*Q_CYC` cycles. So `pwm[1]` rises exactly `Q_CYC` cycles after `pwm[0]`.
- R4: For 0 < duty < `4*Q_CYC`, each output is high for exactly `duty` cycles in every carrier period. Each pulse starts at that phase's own period start.
- R5: A duty of 0 keeps all four outputs low for the whole period.
- R6: A duty at or above `4*Q_CYC` keeps every output high for the whole period.
- R7: A high `duty_vld` at a clock edge stores `duty` in the shadow register. Phase k changes its active duty only at its own period start (master count equal to `k*Q_CYC`), or during ARM. At any other time the change has no effect on that output.
- R8: In RUN, `upd_tick` is high for exactly one cycle at every quarter boundary. That gives four pulses per carrier period. Two ticks are never adjacent unless a sync has just moved the carrier.
- R9: A `sync_pulse` sampled in RUN loads the master count with `sync_qtr*Q_CYC + min(sync_fine, Q_CYC-1)` at that edge. The next `pwm[0]` rise and its tick come `4*Q_CYC - offset + 1` edges later. A sync pulse outside RUN has no effect.
- R10: When `en` rises, the first edge enters ARM and the second enters RUN. The first `upd_tick` (together with `pwm[0]` if duty > 0) appears after the third edge.
- R11: After a sync, the phases keep their quarter-period spacing, so `pwm[1]` still rises `Q_CYC` cycles after `pwm[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces IDLE |
| duty | input | DW | Shared duty word, in clock cycles |
| duty_vld | input | 1 | Stores `duty` in the shadow register |
| sync_pulse | input | 1 | Zero-crossing realignment pulse |
| sync_qtr | input | 2 | Quarter index of the realignment offset |
| sync_fine | input | FW | Fine offset inside the quarter, saturated at `Q_CYC-1` |
| pwm | output | 4 | Gate outputs, bit k lagging by k quarters |
| upd_tick | output | 1 | One-cycle pulse at each quarter boundary |

## Verification
A reference model runs cycle by cycle beside the design and is compared against it. It is checked with a mid-range duty, with a duty that changes part-way through a period, with zero duty and with an over-range duty. These separate correct boundary-gated reload from reload that happens at once, and correct saturation from wrap-around. Sync pulses use an in-range fine offset and an over-range one. The delay to the next rise of `pwm[0]` is measured after each, which shows whether the offset was loaded and saturated correctly. The bench also measures pulse widths, tick counts and the spacing between rises at the ports. This catches errors in period length, quarter lag and tick placement even where the model would share a misunderstanding.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    // Number of interleaved cells and width of the quarter index.
    localparam int NPH = 4;
    localparam int QIW = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } seq_t;
endpackage

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic arm,
    output logic run
);
    seq_t state_q;
    seq_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, launch, halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = en ? ST_ARM : ST_IDLE;
            ST_ARM:  state_d = en ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = en ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        arm = 1'b0;
        run = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                arm = 1'b0;
                run = 1'b0;
            end
            ST_ARM: begin
                arm = 1'b1;
                run = 1'b0;
            end
            ST_RUN: begin
                arm = 1'b0;
                run = 1'b1;
            end
            default: begin
                arm = 1'b0;
                run = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ilv_carrier.sv
module ilv_carrier
    import ilv_pkg::*;
#(
    parameter int Q_CYC = 2500,
    parameter int FW    = 12,
    localparam int QCW  = $clog2(Q_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync,
    input  logic [QIW-1:0]   sync_qtr,
    input  logic [FW-1:0]    sync_fine,
    output logic [QIW-1:0]   qidx,
    output logic [QCW-1:0]   qcnt,
    output logic             tick_q,
    output logic [NPH-1:0]   bnd
);
    localparam logic [QCW-1:0] QLAST = QCW'(Q_CYC - 1);

    logic [QCW-1:0] fine_sat;

    // Fine offset saturates at the last count of a quarter
    always_comb begin
        if (32'(sync_fine) > 32'(Q_CYC - 1)) begin
            fine_sat = QLAST;
        end else begin
            fine_sat = QCW'(sync_fine);
        end
    end

    // Master carrier: quarter index plus count within the quarter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qidx   <= '0;
            qcnt   <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= run && (qcnt == '0);
            if (!run) begin
                qidx <= '0;
                qcnt <= '0;
            end else if (sync) begin
                qidx <= sync_qtr;
                qcnt <= fine_sat;
            end else if (qcnt == QLAST) begin
                qcnt <= '0;
                qidx <= qidx + 1'b1;
            end else begin
                qcnt <= qcnt + 1'b1;
            end
        end
    end

    // Period start of each phase
    for (genvar k = 0; k < NPH; k++) begin : g_bnd
        assign bnd[k] = run && (qcnt == '0) && (qidx == QIW'(k));
    end
endmodule

// File: rtl/ilv_phase.sv
module ilv_phase
    import ilv_pkg::*;
#(
    parameter int K     = 0,
    parameter int Q_CYC = 2500,
    parameter int DW    = 16,
    localparam int QCW  = $clog2(Q_CYC),
    localparam int PW   = $clog2(NPH * Q_CYC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           arm,
    input  logic           bnd,
    input  logic [DW-1:0]  shadow,
    input  logic [QIW-1:0] qidx,
    input  logic [QCW-1:0] qcnt,
    output logic           pwm_q,
    output logic [DW-1:0]  act_q
);
    logic [QIW-1:0] lag_qtr;
    logic [PW-1:0]  ph;
    logic [DW-1:0]  act_eff;

    // Local carrier position, lagging the master by K quarters
    assign lag_qtr = qidx - QIW'(K);
    assign ph      = PW'(lag_qtr) * PW'(Q_CYC) + PW'(qcnt);

    // New duty applies from the first count of this phase's period
    assign act_eff = bnd ? shadow : act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            if (arm || bnd) begin
                act_q <= shadow;
            end
            pwm_q <= run && (32'(ph) < 32'(act_eff));
        end
    end
endmodule

// File: rtl/ilv_pwm4.sv
module ilv_pwm4
    import ilv_pkg::*;
#(
    parameter int Q_CYC = 2500,
    parameter int DW    = 16,
    parameter int FW    = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [DW-1:0]  duty,
    input  logic           duty_vld,
    input  logic           sync_pulse,
    input  logic [QIW-1:0] sync_qtr,
    input  logic [FW-1:0]  sync_fine,
    output logic [NPH-1:0] pwm,
    output logic           upd_tick
);
    localparam int QCW = $clog2(Q_CYC);

    logic                    arm_w;
    logic                    run_w;
    logic [QIW-1:0]          qidx_w;
    logic [QCW-1:0]          qcnt_w;
    logic [NPH-1:0]          bnd_w;
    logic [DW-1:0]           shadow_q;
    logic [NPH-1:0][DW-1:0]  act_w;

    // Shadow duty register, written by the controller at any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (duty_vld) begin
            shadow_q <= duty;
        end
    end

    ilv_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .arm   (arm_w),
        .run   (run_w)
    );

    ilv_carrier #(
        .Q_CYC (Q_CYC),
        .FW    (FW)
    ) u_car (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .sync      (sync_pulse),
        .sync_qtr  (sync_qtr),
        .sync_fine (sync_fine),
        .qidx      (qidx_w),
        .qcnt      (qcnt_w),
        .tick_q    (upd_tick),
        .bnd       (bnd_w)
    );

    for (genvar k = 0; k < NPH; k++) begin : g_ph
        ilv_phase #(
            .K     (k),
            .Q_CYC (Q_CYC),
            .DW    (DW)
        ) u_ph (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_w),
            .arm    (arm_w),
            .bnd    (bnd_w[k]),
            .shadow (shadow_q),
            .qidx   (qidx_w),
            .qcnt   (qcnt_w),
            .pwm_q  (pwm[k]),
            .act_q  (act_w[k])
        );
    end
endmodule

// File: rtl/ilv_pwm4_chk.sv
module ilv_pwm4_chk
    import ilv_pkg::*;
#(
    parameter int DW = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sync_pulse,
    input logic                   run,
    input logic                   arm,
    input logic [NPH-1:0]         pwm,
    input logic                   upd_tick,
    input logic [NPH-1:0]         bnd,
    input logic [NPH-1:0][DW-1:0] act
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm == '0 && !upd_tick));

    // R10
    arm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !arm);

    // R10
    run_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(arm));

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && !$past(sync_pulse)) |=> !upd_tick);

    // R2
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwm[0]) && !$past(sync_pulse) && !$past(sync_pulse, 2)) |-> upd_tick);

    for (genvar k = 0; k < NPH; k++) begin : g_hold
        // R7
        act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(act[k]) |-> $past(bnd[k] || arm));
    end
endmodule

bind ilv_pwm4 ilv_pwm4_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pulse (sync_pulse),
    .run        (run_w),
    .arm        (arm_w),
    .pwm        (pwm),
    .upd_tick   (upd_tick),
    .bnd        (bnd_w),
    .act        (act_w)
);

// File: tb/sim_ilv_pwm4.sv
module sim_ilv_pwm4;
    localparam int CLK_NS = 10;
    localparam int Q      = 25;
    localparam int P      = 4 * Q;
    localparam int DW     = 16;
    localparam int FW     = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [DW-1:0] duty = '0;
    logic          duty_vld = 1'b0;
    logic          sync_pulse = 1'b0;
    logic [1:0]    sync_qtr = '0;
    logic [FW-1:0] sync_fine = '0;
    logic [3:0]    pwm;
    logic          upd_tick;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int         m_st = 0;
    int         m_c = 0;
    int         m_sh = 0;
    int         m_act[4] = '{0, 0, 0, 0};
    logic [4:0] exp_q[$];

    ilv_pwm4 #(.Q_CYC(Q), .DW(DW), .FW(FW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .duty       (duty),
        .duty_vld   (duty_vld),
        .sync_pulse (sync_pulse),
        .sync_qtr   (sync_qtr),
        .sync_fine  (sync_fine),
        .pwm        (pwm),
        .upd_tick   (upd_tick)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver side: predict the outputs each edge produces, push into the queue
    task automatic predict();
        logic [3:0] ep;
        logic       et;
        int         a;
        int         ph;
        int         fs;
        ep = '0;
        et = 1'b0;
        if (!rst_n) begin
            m_st = 0;
            m_c  = 0;
            m_sh = 0;
            for (int k = 0; k < 4; k++) m_act[k] = 0;
        end else begin
            if (m_st == 2) begin
                et = ((m_c % Q) == 0);
                for (int k = 0; k < 4; k++) begin
                    ph = (m_c - k * Q + P) % P;
                    a  = (ph == 0) ? m_sh : m_act[k];
                    ep[k] = (ph < a);
                    m_act[k] = a;
                end
            end else if (m_st == 1) begin
                for (int k = 0; k < 4; k++) m_act[k] = m_sh;
            end
            if (m_st == 2) begin
                fs = (int'(sync_fine) > Q - 1) ? Q - 1 : int'(sync_fine);
                m_c = sync_pulse ? (int'(sync_qtr) * Q + fs) : ((m_c + 1) % P);
            end else begin
                m_c = 0;
            end
            if (duty_vld) m_sh = int'(duty);
            if (!en) m_st = 0;
            else if (m_st < 2) m_st = m_st + 1;
        end
        exp_q.push_back({et, ep});
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        predict();
    end

    // Monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        logic [4:0] e;
        if (exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            n_chk++;
            if ({upd_tick, pwm} !== e) begin
                n_err++;
                $display("FAIL %s scoreboard actual=%0d expected=%0d", cur_req,
                         int'({upd_tick, pwm}), int'(e));
            end
        end
    end

    task automatic wait_rise(input int k, output int t);
        logic prev;
        int   lim;
        prev = pwm[k];
        lim  = 0;
        t    = -1;
        while (lim < 10 * P) begin
            @(negedge clk);
            lim++;
            if (pwm[k] && !prev) begin
                t = cyc;
                break;
            end
            prev = pwm[k];
        end
    endtask

    task automatic cnt_high(input int k, input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            c += int'(pwm[k]);
        end
    endtask

    task automatic set_duty(input int d);
        duty     = DW'(d);
        duty_vld = 1'b1;
        @(negedge clk);
        duty_vld = 1'b0;
    endtask

    task automatic sync_delay(input int qtr, input int fine, output int m);
        int t;
        wait_rise(0, t);
        repeat (40) @(negedge clk);
        sync_qtr   = 2'(qtr);
        sync_fine  = FW'(fine);
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        m = 1;
        while (!pwm[0] && m < 3 * P) begin
            @(negedge clk);
            m++;
        end
    endtask

    initial begin
        int t0, t1, t2, c, m;
        repeat (4) @(negedge clk);
        cur_req = "R1";
        chk(pwm == 4'b0 && !upd_tick, "R1", int'({upd_tick, pwm}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(pwm == 4'b0 && !upd_tick, "R1", int'({upd_tick, pwm}), 0);

        // start sequence
        cur_req  = "R10";
        duty     = DW'(30);
        duty_vld = 1'b1;
        en       = 1'b1;
        @(negedge clk);
        duty_vld = 1'b0;
        @(negedge clk);
        chk(!upd_tick, "R10", int'(upd_tick), 0);
        @(negedge clk);
        chk(upd_tick && pwm[0], "R10", int'({upd_tick, pwm[0]}), 3);

        cur_req = "R2";
        wait_rise(0, t0);
        wait_rise(0, t1);
        chk(t1 - t0 == P, "R2", t1 - t0, P);
        cur_req = "R3";
        wait_rise(1, t2);
        chk(t2 - t1 == Q, "R3", t2 - t1, Q);
        cur_req = "R4";
        cnt_high(2, P, c);
        chk(c == 30, "R4", c, 30);
        cur_req = "R8";
        c = 0;
        repeat (P) begin
            @(negedge clk);
            c += int'(upd_tick);
        end
        chk(c == 4, "R8", c, 4);

        // duty change part-way through a period
        cur_req = "R7";
        repeat (13) @(negedge clk);
        set_duty(60);
        repeat (2 * P) @(negedge clk);
        cnt_high(3, P, c);
        chk(c == 60, "R7", c, 60);

        cur_req = "R5";
        set_duty(0);
        repeat (2 * P) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            cnt_high(k, P, c);
            chk(c == 0, "R5", c, 0);
        end

        cur_req = "R6";
        set_duty(150);
        repeat (2 * P) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            cnt_high(k, P, c);
            chk(c == P, "R6", c, P);
        end

        cur_req = "R9";
        set_duty(30);
        repeat (2 * P) @(negedge clk);
        sync_delay(1, 7, m);
        chk(m == P - 32 + 2, "R9", m, P - 32 + 2);
        cur_req = "R11";
        t1 = cyc;
        wait_rise(1, t2);
        chk(t2 - t1 == Q, "R11", t2 - t1, Q);
        cur_req = "R9";
        sync_delay(2, 40, m);
        chk(m == P - 74 + 2, "R9", m, P - 74 + 2);

        // leave RUN; sync outside RUN must do nothing
        cur_req = "R1";
        en = 1'b0;
        repeat (2) @(negedge clk);
        c = 0;
        sync_pulse = 1'b1;
        repeat (10) begin
            @(negedge clk);
            c += int'(pwm != 4'b0) + int'(upd_tick);
        end
        sync_pulse = 1'b0;
        chk(c == 0, "R1", c, 0);
        cur_req = "R9";
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk(upd_tick && pwm[0], "R9", int'({upd_tick, pwm[0]}), 3);
        repeat (P) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule